// File: doc/BRIEF.md
# Peak Phase Overshoot Tracker

This block runs in the oscillator clock domain of a clock multiplier under test. It measures how far the feedback divider runs ahead of the reference after a deliberate phase step. On every synchronized reference rising pulse it copies the live divider count into a sample register. That sample is compared with a running maximum, and the maximum takes the sample on the next synchronized reference falling pulse if the sample is larger. When the loop rings, the count wraps to values close to the divisor. Any sample above half the divisor is treated as undershoot and has no effect.

A start pulse clears the block and selects one of four modes. Peak mode waits until the crossover measurement reports valid before it tracks. Calibration mode tracks at once, so with no step applied it reports the synchronizer latency in oscillator cycles. Trend mode takes a single raw capture after a programmed number of reference cycles, which lets software build a step-response trace point by point. Lock mode repeats calibration windows and flags lock when consecutive windows agree.

Top module: `overshoot_peak_tracker`

## Requirements
- R1: After reset, `peak` is 0, `done` is 0 and `locked` is 0.
- R2: A `start` pulse latches `mode` and clears `peak`, `done`, `locked` and any pending sample, visible in the cycle after the pulse.
- R3: In peak mode (`mode`=0), rising pulses seen before `xover_valid` has been observed high take no sample and leave `peak` at 0.
- R4: While tracking, a rising pulse stores `fb_count` as the sample. `peak` does not change on the rising pulse. It takes the sample in the cycle after the next falling pulse, and only if the sample is greater than `peak`.
- R5: A sample greater than floor(`divisor`/2) is ignored as undershoot. A sample equal to floor(`divisor`/2) is accepted.
- R6: A sample less than or equal to `peak` leaves `peak` unchanged.
- R7: In calibration mode (`mode`=1), tracking begins right after `start`, whatever the level of `xover_valid`.
- R8: In trend mode (`mode`=2), on the `trend_len`-th rising pulse after `start` (`trend_len` from 1 to 63), `peak` takes `fb_count` unfiltered in the next cycle and `done` rises. Later pulses have no effect until the next `start`.
- R9: In lock mode (`mode`=3), a window spans `trend_len` rising pulses and closes on the first falling pulse after the last of them. The window result is that window's peak. At the close, `locked` is set if the result equals the previous window's result and cleared otherwise, and `peak` returns to 0 for the next window.
- R10: If `start` arrives in the same cycle as a falling pulse that would update `peak`, the start wins and `peak` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle pulse that begins a measurement |
| mode | input | 2 | 0 peak, 1 calibration, 2 trend, 3 lock |
| xover_valid | input | 1 | Crossover measurement complete |
| ref_rise | input | 1 | Synchronized reference rising-edge pulse |
| ref_fall | input | 1 | Synchronized reference falling-edge pulse |
| fb_count | input | CW | Live feedback divider count |
| divisor | input | CW | Feedback divisor N |
| trend_len | input | CW | Capture point (trend) or window length (lock), in reference cycles |
| peak | output | CW | Running maximum overshoot, or the trend capture |
| done | output | 1 | Trend capture taken |
| locked | output | 1 | Two consecutive lock-mode windows agree |

## Verification
A start pulse can land in the same cycle as a falling pulse that carries a pending update of the maximum. The bench provokes this by latching a sample larger than the current maximum and then raising `start` and `ref_fall` together. It judges the outcome by `peak` reading 0 afterwards, and by a later lone falling pulse still leaving it at 0, which shows the pending sample was dropped. Lock mode has a similar coincidence: the window close and the final update share a falling pulse, so the closing result must already include that last sample.

// File: rtl/overshoot_peak_tracker.sv
module overshoot_peak_tracker #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic          xover_valid,
  input  logic          ref_rise,
  input  logic          ref_fall,
  input  logic [CW-1:0] fb_count,
  input  logic [CW-1:0] divisor,
  input  logic [CW-1:0] trend_len,
  output logic [CW-1:0] peak,
  output logic          done,
  output logic          locked
);

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_RUN, S_DONE} st_t;

  st_t           st;
  logic [1:0]    md;
  logic [CW-1:0] smpl, cnt, prev;
  logic          smpl_vld, have_prev;

  wire [CW-1:0] half     = divisor >> 1;
  wire [CW-1:0] cnt_nx   = cnt + 1'b1;
  wire          trend_m  = (md == 2'd2);
  wire          lock_m   = (md == 2'd3);
  wire          win_full = (cnt == trend_len);
  wire          running  = (st == S_RUN);
  wire          upd      = running && smpl_vld && (smpl > peak) && (smpl <= half);
  wire          take     = running && ref_rise && !(lock_m && win_full);
  wire          close_w  = running && lock_m && ref_fall && win_full;
  wire [CW-1:0] win_res  = upd ? smpl : peak;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      md        <= 2'd0;
      smpl      <= '0;
      smpl_vld  <= 1'b0;
      cnt       <= '0;
      prev      <= '0;
      have_prev <= 1'b0;
      peak      <= '0;
      done      <= 1'b0;
      locked    <= 1'b0;
    end else if (start) begin
      md        <= mode;
      st        <= (mode == 2'd0) ? S_ARM : S_RUN;
      peak      <= '0;
      smpl_vld  <= 1'b0;
      cnt       <= '0;
      done      <= 1'b0;
      locked    <= 1'b0;
      have_prev <= 1'b0;
    end else begin
      case (st)
        S_ARM: if (xover_valid) st <= S_RUN;
        S_RUN: begin
          if (trend_m) begin
            if (ref_rise) begin
              cnt <= cnt_nx;
              if (cnt_nx == trend_len) begin
                peak <= fb_count;
                done <= 1'b1;
                st   <= S_DONE;
              end
            end
          end else begin
            if (take) begin
              smpl     <= fb_count;
              smpl_vld <= 1'b1;
              if (lock_m) cnt <= cnt_nx;
            end
            if (ref_fall && upd) peak <= smpl;
            if (close_w) begin
              locked    <= have_prev && (win_res == prev);
              prev      <= win_res;
              have_prev <= 1'b1;
              peak      <= '0;
              cnt       <= '0;
              smpl_vld  <= 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R6: outside lock and trend modes the maximum never falls while tracking
  p_peak_monotone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && $past(st) == S_RUN && !md[1] && !$past(start)) |-> (peak >= $past(peak)));

  // R4 and R5: growth only after a falling pulse, and never past half the divisor
  p_rise_filtered_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && md != 2'd2 && peak > $past(peak))
      |-> ($past(ref_fall) && peak <= ($past(divisor) >> 1)));

  // R8: a finished trend capture stays put
  p_trend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(peak)));

  // R2 and R10: start clears everything, even with a coinciding fall
  p_start_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (peak == '0 && !done && !locked));

  // R9: lock only rises at a window close
  p_lock_at_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(md == 2'd3 && ref_fall && cnt == trend_len));

endmodule

// File: tb/overshoot_peak_tracker_bench.sv
module overshoot_peak_tracker_bench;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic xover_valid = 1'b0;
  logic ref_rise = 1'b0;
  logic ref_fall = 1'b0;
  logic [CW-1:0] fb_count = '0;
  logic [CW-1:0] divisor = 6'd8;
  logic [CW-1:0] trend_len = 6'd1;
  logic [CW-1:0] peak;
  logic done, locked;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  overshoot_peak_tracker #(.CW(CW)) u_overshoot_peak_tracker (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .xover_valid(xover_valid), .ref_rise(ref_rise), .ref_fall(ref_fall),
    .fb_count(fb_count), .divisor(divisor), .trend_len(trend_len),
    .peak(peak), .done(done), .locked(locked));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic kick(input logic [1:0] m);
    @(negedge clk); mode = m; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic rise(input int v);
    @(negedge clk); fb_count = v[CW-1:0]; ref_rise = 1'b1;
    @(negedge clk); ref_rise = 1'b0;
  endtask

  task automatic fall();
    @(negedge clk); ref_fall = 1'b1;
    @(negedge clk); ref_fall = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 peak", peak, 0);
    check("R1 done", done, 0);
    check("R1 locked", locked, 0);
  endtask

  task automatic t_peak_mode();
    divisor = 6'd8; xover_valid = 1'b0;
    kick(2'd0);
    rise(3); fall();
    check("R3 no sample before crossover", peak, 0);
    @(negedge clk); xover_valid = 1'b1;
    @(negedge clk);
    rise(2); fall();
    check("R4 first update", peak, 2);
    rise(3);
    check("R4 no change on rise", peak, 2);
    fall();
    check("R4 update after fall", peak, 3);
    rise(1); fall();
    check("R6 smaller sample kept out", peak, 3);
    rise(7); fall();
    check("R5 undershoot ignored", peak, 3);
    rise(4); fall();
    check("R5 half accepted", peak, 4);
    rise(5); fall();
    check("R5 above half ignored", peak, 4);
    xover_valid = 1'b0;
  endtask

  task automatic t_cal();
    kick(2'd1);
    rise(2); fall();
    check("R7 calibration tracks at once", peak, 2);
    kick(2'd1);
    check("R2 start clears peak", peak, 0);
  endtask

  task automatic t_trend();
    trend_len = 6'd3;
    kick(2'd2);
    rise(1); fall(); rise(2); fall();
    check("R8 no capture before M", peak, 0);
    check("R8 done low before M", done, 0);
    rise(7);
    check("R8 raw capture", peak, 7);
    check("R8 done", done, 1);
    rise(5); fall();
    check("R8 later pulses ignored", peak, 7);
    kick(2'd1);
    check("R2 start clears done", done, 0);
  endtask

  task automatic t_lock();
    trend_len = 6'd2; divisor = 6'd8;
    kick(2'd3);
    rise(1); fall();
    check("R9 window running peak", peak, 1);
    rise(2); fall();
    check("R9 first window not locked", locked, 0);
    check("R9 peak cleared at close", peak, 0);
    rise(2); fall();
    check("R9 second window peak", peak, 2);
    rise(1); fall();
    check("R9 lock on match", locked, 1);
    rise(3); fall(); rise(0); fall();
    check("R9 lock cleared on mismatch", locked, 0);
    kick(2'd1);
    check("R2 start clears locked", locked, 0);
  endtask

  task automatic t_collide();
    kick(2'd1);
    rise(3); fall();
    check("R10 setup", peak, 3);
    rise(4);
    @(negedge clk); ref_fall = 1'b1; start = 1'b1; mode = 2'd1;
    @(negedge clk); ref_fall = 1'b0; start = 1'b0;
    check("R10 start beats update", peak, 0);
    fall();
    check("R10 pending sample dropped", peak, 0);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_peak_mode();
    t_cal();
    t_trend();
    t_lock();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule